// File: doc/BRIEF.md
# Dictionary Liveness Sweeper

This block keeps a compression dictionary free of stale entries. It does not keep a reference count for each entry. It holds two banks of one-bit flags, with one flag per dictionary code. An entry counts as live while either bank has its flag set.

Flags are set in three ways:
- A codec access to a code sets that code's flag.
- Allocating a new code sets that code's flag.
- A slow marking sweep reads the cache one line at a time and sets the flag of every code that a compressed line holds.

When the marking sweep finishes a full pass over the cache, the two banks swap roles and the bank that becomes current is cleared. An entry that is no longer used therefore stays live for at least one complete pass after its last touch.

A second sweep walks the dictionary codes above the literal range. It frees any allocated code that no bank flags and that no line response in the same cycle references. Each freed code goes into a small free-code FIFO, and the code allocator drains that FIFO to reuse the codes.

Both sweeps step at most once per cycle and yield to other traffic. The marking sweep issues no line read while the cache read port is busy. The purge sweep holds still in any cycle that carries a codec mark or an allocation.

Top module: `dict_liveness_sweep`

## Requirements
- R1: After reset, no code is allocated, no flag is set, and `free_valid` is 0.
- R2: Codes below LITERALS (256) are fixed single-symbol codes. An allocation of such a code is ignored, and such a code never appears on `free_code`.
- R3: A code that was never allocated never appears on `free_code`.
- R4: An allocated code that no codec mark and no compressed cache line references is presented on `free_code` within a bounded time (two cache passes plus one dictionary pass, plus any stall time).
- R5: A code held in slot i of a line whose response has `line_rsp_compressed` = 1 and `line_rsp_mask[i]` = 1 is never freed. Slot i occupies `line_rsp_codes[i*CODE_W +: CODE_W]`.
- R6: A code gets no protection from a line whose `line_rsp_compressed` is 0, or from a slot whose mask bit is 0.
- R7: A code marked through `mark_valid` at intervals shorter than one cache pass is never freed. Once the marks stop, it is freed.
- R8: `line_rd_en` is 0 in every cycle in which `line_port_busy` is 1. While the port stays busy the banks do not rotate, so flags that are already set persist.
- R9: The purge sweep does not advance in a cycle where `mark_valid` or `alloc_valid` is 1. While such traffic is continuous, nothing is freed.
- R10: Each allocation of a code leads to at most one appearance of that code on `free_code`. A freed code that is allocated again can be freed again.
- R11: While `free_valid` = 1 and `free_ready` = 0, `free_code` holds steady. When the FIFO is full the purge sweep waits, so no freed code is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_valid | input | 1 | Codec touched a dictionary code this cycle |
| mark_code | input | CODE_W | Code touched by the codec |
| alloc_valid | input | 1 | Allocator placed a new entry this cycle |
| alloc_code | input | CODE_W | Code of the new entry |
| line_port_busy | input | 1 | Cache read port is taken by the codec this cycle |
| line_rd_en | output | 1 | Marking sweep requests a cache line |
| line_rd_idx | output | LINE_W | Index of the requested line |
| line_rsp_valid | input | 1 | Line response present |
| line_rsp_compressed | input | 1 | Responding line is stored compressed |
| line_rsp_mask | input | SLOTS | Slot i carries a code |
| line_rsp_codes | input | SLOTS*CODE_W | Codes of the line, slot i at bits i*CODE_W |
| free_valid | output | 1 | A freed code is waiting |
| free_code | output | CODE_W | Oldest freed code |
| free_ready | input | 1 | Allocator accepts the freed code |

## Verification
A line response can mark a code in the same cycle that the purge sweep visits that code with both bank flags clear. The purge check therefore also compares the code under test against the live line response. A checker property flags any free of a code present in a compressed slot of that same response. The bench keeps referenced codes in cache lines while the purge sweep and the marking sweep run side by side for thousands of cycles, and any free of those codes is a failure. A codec mark also falls into purge cycles: the bench holds `mark_valid` high for a long window and expects no free until it drops.

// File: rtl/dls_pkg.sv
package dls_pkg;
    localparam int DLS_ENTRIES    = 512;
    localparam int DLS_LITERALS   = 256;
    localparam int DLS_LINES      = 8;
    localparam int DLS_SLOTS      = 4;
    localparam int DLS_FREE_DEPTH = 4;

    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_sel_e;

    function automatic int unsigned wrap_next(input int unsigned cur,
                                              input int unsigned lo,
                                              input int unsigned hi);
        return (cur >= hi) ? lo : cur + 1;
    endfunction
endpackage

// File: rtl/dls_line_sweep.sv
module dls_line_sweep #(
    parameter int LINES  = 8,
    parameter int SLOTS  = 4,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_busy,
    input  logic              rsp_valid,
    input  logic              rsp_compressed,
    input  logic [SLOTS-1:0]  rsp_mask,
    output logic              rd_en,
    output logic [LINE_W-1:0] rd_idx,
    output logic [SLOTS-1:0]  slot_mark,
    output logic              pass_done
);
    logic waiting;
    logic take;

    assign rd_en     = !waiting && !port_busy;
    assign take      = waiting && rsp_valid;
    assign slot_mark = (take && rsp_compressed) ? rsp_mask : '0;
    assign pass_done = take && (rd_idx == LINE_W'(LINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
            rd_idx  <= '0;
        end else begin
            if (rd_en) waiting <= 1'b1;
            if (take) begin
                waiting <= 1'b0;
                rd_idx  <= LINE_W'(dls_pkg::wrap_next(32'(rd_idx), 0, LINES - 1));
            end
        end
    end
endmodule

// File: rtl/dls_flag_banks.sv
module dls_flag_banks #(
    parameter int ENTRIES  = 512,
    parameter int LITERALS = 256,
    parameter int SLOTS    = 4,
    parameter int CODE_W   = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mark_en,
    input  logic [CODE_W-1:0]       mark_code,
    input  logic                    alloc_en,
    input  logic [CODE_W-1:0]       alloc_code,
    input  logic [SLOTS-1:0]        slot_mark,
    input  logic [SLOTS*CODE_W-1:0] slot_codes,
    input  logic                    swap,
    input  logic                    release_en,
    input  logic [CODE_W-1:0]       release_code,
    input  logic [CODE_W-1:0]       query,
    output logic                    query_live,
    output logic                    query_alloc
);
    import dls_pkg::*;

    logic [ENTRIES-1:0] bank_a, bank_b, alloc_map;
    bank_sel_e          cur, tgt;
    logic               line_ref;

    assign tgt = swap ? ((cur == BANK_A) ? BANK_B : BANK_A) : cur;

    always_comb begin
        line_ref = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            if (slot_mark[i] && slot_codes[i*CODE_W +: CODE_W] == query) line_ref = 1'b1;
    end

    assign query_live  = bank_a[query] | bank_b[query] | line_ref;
    assign query_alloc = alloc_map[query];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_a    <= '0;
            bank_b    <= '0;
            alloc_map <= '0;
            cur       <= BANK_A;
        end else begin
            // line marks land in the bank that is current before any swap
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_mark[i]) begin
                    if (cur == BANK_A) bank_a[slot_codes[i*CODE_W +: CODE_W]] <= 1'b1;
                    else               bank_b[slot_codes[i*CODE_W +: CODE_W]] <= 1'b1;
                end
            end
            if (swap) begin
                cur <= tgt;
                if (tgt == BANK_A) bank_a <= '0;
                else               bank_b <= '0;
            end
            if (mark_en) begin
                if (tgt == BANK_A) bank_a[mark_code] <= 1'b1;
                else               bank_b[mark_code] <= 1'b1;
            end
            if (release_en) alloc_map[release_code] <= 1'b0;
            if (alloc_en && 32'(alloc_code) >= LITERALS) begin
                alloc_map[alloc_code] <= 1'b1;
                if (tgt == BANK_A) bank_a[alloc_code] <= 1'b1;
                else               bank_b[alloc_code] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dls_purge_sweep.sv
module dls_purge_sweep #(
    parameter int ENTRIES  = 512,
    parameter int LITERALS = 256,
    parameter int CODE_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_busy,
    input  logic              fifo_full,
    input  logic              live,
    input  logic              allocated,
    output logic [CODE_W-1:0] ptr,
    output logic              push_en
);
    logic step;

    assign step    = !port_busy && !fifo_full;
    assign push_en = step && allocated && !live;

    always_ff @(posedge clk) begin
        if (rst)       ptr <= CODE_W'(LITERALS);
        else if (step) ptr <= CODE_W'(dls_pkg::wrap_next(32'(ptr), LITERALS, ENTRIES - 1));
    end
endmodule

// File: rtl/dls_free_fifo.sv
module dls_free_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    output logic             full,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    input  logic             out_ready,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= PTR_W'(dls_pkg::wrap_next(32'(wr_ptr), 0, DEPTH - 1));
            end
            if (pop) rd_ptr <= PTR_W'(dls_pkg::wrap_next(32'(rd_ptr), 0, DEPTH - 1));
            count <= count + CNT_W'(push && !full) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/dict_liveness_sweep.sv
module dict_liveness_sweep #(
    parameter int ENTRIES    = dls_pkg::DLS_ENTRIES,
    parameter int LITERALS   = dls_pkg::DLS_LITERALS,
    parameter int LINES      = dls_pkg::DLS_LINES,
    parameter int SLOTS      = dls_pkg::DLS_SLOTS,
    parameter int FREE_DEPTH = dls_pkg::DLS_FREE_DEPTH,
    localparam int CODE_W    = $clog2(ENTRIES),
    localparam int LINE_W    = $clog2(LINES),
    localparam int CNT_W     = $clog2(FREE_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mark_valid,
    input  logic [CODE_W-1:0]       mark_code,
    input  logic                    alloc_valid,
    input  logic [CODE_W-1:0]       alloc_code,
    input  logic                    line_port_busy,
    output logic                    line_rd_en,
    output logic [LINE_W-1:0]       line_rd_idx,
    input  logic                    line_rsp_valid,
    input  logic                    line_rsp_compressed,
    input  logic [SLOTS-1:0]        line_rsp_mask,
    input  logic [SLOTS*CODE_W-1:0] line_rsp_codes,
    output logic                    free_valid,
    output logic [CODE_W-1:0]       free_code,
    input  logic                    free_ready
);
    logic [SLOTS-1:0]  line_mark_en;
    logic              pass_done;
    logic [CODE_W-1:0] purge_ptr;
    logic              purge_live, purge_alloc, push_en, fifo_full;
    logic [CNT_W-1:0]  fifo_count;

    dls_line_sweep #(.LINES(LINES), .SLOTS(SLOTS), .LINE_W(LINE_W)) u_line (
        .clk(clk), .rst(rst), .port_busy(line_port_busy),
        .rsp_valid(line_rsp_valid), .rsp_compressed(line_rsp_compressed),
        .rsp_mask(line_rsp_mask), .rd_en(line_rd_en), .rd_idx(line_rd_idx),
        .slot_mark(line_mark_en), .pass_done(pass_done)
    );

    dls_flag_banks #(.ENTRIES(ENTRIES), .LITERALS(LITERALS), .SLOTS(SLOTS),
                     .CODE_W(CODE_W)) u_flags (
        .clk(clk), .rst(rst), .mark_en(mark_valid), .mark_code(mark_code),
        .alloc_en(alloc_valid), .alloc_code(alloc_code),
        .slot_mark(line_mark_en), .slot_codes(line_rsp_codes), .swap(pass_done),
        .release_en(push_en), .release_code(purge_ptr), .query(purge_ptr),
        .query_live(purge_live), .query_alloc(purge_alloc)
    );

    dls_purge_sweep #(.ENTRIES(ENTRIES), .LITERALS(LITERALS), .CODE_W(CODE_W)) u_purge (
        .clk(clk), .rst(rst), .port_busy(mark_valid || alloc_valid),
        .fifo_full(fifo_full), .live(purge_live), .allocated(purge_alloc),
        .ptr(purge_ptr), .push_en(push_en)
    );

    dls_free_fifo #(.DEPTH(FREE_DEPTH), .W(CODE_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push_en), .push_data(purge_ptr),
        .full(fifo_full), .out_valid(free_valid), .out_data(free_code),
        .out_ready(free_ready), .count(fifo_count)
    );
endmodule

// File: rtl/dls_liveness_checker.sv
module dls_liveness_checker #(
    parameter int LITERALS   = 256,
    parameter int SLOTS      = 4,
    parameter int FREE_DEPTH = 4,
    parameter int CODE_W     = 9,
    parameter int CNT_W      = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    mark_valid,
    input logic                    alloc_valid,
    input logic                    line_port_busy,
    input logic                    line_rd_en,
    input logic                    line_rsp_valid,
    input logic                    line_rsp_compressed,
    input logic [SLOTS-1:0]        line_rsp_mask,
    input logic [SLOTS*CODE_W-1:0] line_rsp_codes,
    input logic                    free_valid,
    input logic [CODE_W-1:0]       free_code,
    input logic                    free_ready,
    input logic [CODE_W-1:0]       purge_ptr,
    input logic                    push_en,
    input logic [CNT_W-1:0]        fifo_count
);
    logic rsp_holds_ptr;
    always_comb begin
        rsp_holds_ptr = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            if (line_rsp_valid && line_rsp_compressed && line_rsp_mask[i] &&
                line_rsp_codes[i*CODE_W +: CODE_W] == purge_ptr) rsp_holds_ptr = 1'b1;
    end

    a_r8_no_read_when_busy: assert property (@(posedge clk) disable iff (rst)
        line_port_busy |-> !line_rd_en);
    a_r9_purge_yields: assert property (@(posedge clk) disable iff (rst)
        (mark_valid || alloc_valid) |=> $stable(purge_ptr));
    a_r2_no_literal_free: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> (32'(free_code) >= LITERALS));
    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (free_valid && !free_ready) |=> (free_valid && $stable(free_code)));
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_count) <= FREE_DEPTH);
    a_r5_line_ref_kept: assert property (@(posedge clk) disable iff (rst)
        push_en |-> !rsp_holds_ptr);
endmodule

bind dict_liveness_sweep dls_liveness_checker #(
    .LITERALS(LITERALS), .SLOTS(SLOTS), .FREE_DEPTH(FREE_DEPTH),
    .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .mark_valid(mark_valid), .alloc_valid(alloc_valid),
    .line_port_busy(line_port_busy), .line_rd_en(line_rd_en),
    .line_rsp_valid(line_rsp_valid), .line_rsp_compressed(line_rsp_compressed),
    .line_rsp_mask(line_rsp_mask), .line_rsp_codes(line_rsp_codes),
    .free_valid(free_valid), .free_code(free_code), .free_ready(free_ready),
    .purge_ptr(purge_ptr), .push_en(push_en), .fifo_count(fifo_count)
);

// File: tb/dict_liveness_sweep_tb_top.sv
module dict_liveness_sweep_tb_top;
    localparam int CODE_W = 9;
    localparam int LINE_W = 3;
    localparam int SLOTS  = 4;
    localparam int LINES  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mark_valid = 1'b0, alloc_valid = 1'b0, line_port_busy = 1'b0, free_ready = 1'b1;
    logic [CODE_W-1:0] mark_code = '0, alloc_code = '0;
    logic line_rd_en, line_rsp_valid, line_rsp_compressed, free_valid;
    logic [LINE_W-1:0] line_rd_idx;
    logic [SLOTS-1:0] line_rsp_mask;
    logic [SLOTS*CODE_W-1:0] line_rsp_codes;
    logic [CODE_W-1:0] free_code;

    int checks = 0, fails = 0, cycles = 0, unexpected = 0;
    int exp_q[$];

    logic                    cmp_m  [LINES];
    logic [SLOTS-1:0]        mask_m [LINES];
    logic [SLOTS*CODE_W-1:0] codes_m[LINES];

    always #2 clk = ~clk;

    dict_liveness_sweep dut_i (
        .clk(clk), .rst(rst), .mark_valid(mark_valid), .mark_code(mark_code),
        .alloc_valid(alloc_valid), .alloc_code(alloc_code),
        .line_port_busy(line_port_busy), .line_rd_en(line_rd_en), .line_rd_idx(line_rd_idx),
        .line_rsp_valid(line_rsp_valid), .line_rsp_compressed(line_rsp_compressed),
        .line_rsp_mask(line_rsp_mask), .line_rsp_codes(line_rsp_codes),
        .free_valid(free_valid), .free_code(free_code), .free_ready(free_ready)
    );

    // cache model: answers one cycle after a read request
    always @(posedge clk) begin
        line_rsp_valid      <= line_rd_en && !rst;
        line_rsp_compressed <= cmp_m[line_rd_idx];
        line_rsp_mask       <= mask_m[line_rd_idx];
        line_rsp_codes      <= codes_m[line_rd_idx];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: each accepted free must match a pending expectation
    always @(negedge clk) begin
        cycles++;
        if (!rst && free_valid && free_ready) begin
            int hit;
            hit = -1;
            foreach (exp_q[k]) if (hit < 0 && exp_q[k] == int'(free_code)) hit = k;
            if (hit >= 0) exp_q.delete(hit);
            else unexpected++;
            check(hit >= 0, "R3/R10 free of unexpected code", int'(free_code), -1);
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic alloc(input int code);
        @(posedge clk); #1;
        alloc_valid = 1'b1; alloc_code = CODE_W'(code);
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic mark(input int code);
        @(posedge clk); #1;
        mark_valid = 1'b1; mark_code = CODE_W'(code);
        @(posedge clk); #1;
        mark_valid = 1'b0;
    endtask

    initial begin
        for (int l = 0; l < LINES; l++) begin
            cmp_m[l] = 1'b1; mask_m[l] = '0; codes_m[l] = '0;
        end
        cmp_m[3] = 1'b1; mask_m[3] = 4'b0001; codes_m[3][0 +: CODE_W] = 9'd310;
        cmp_m[5] = 1'b0; mask_m[5] = 4'b1111; codes_m[5][CODE_W +: CODE_W] = 9'd311;
        cmp_m[6] = 1'b1; mask_m[6] = 4'b1110; codes_m[6][0 +: CODE_W] = 9'd312;
        ticks(4);
        check(free_valid == 1'b0, "R1 reset free_valid", int'(free_valid), 0);
        rst = 1'b0;
        ticks(2);
        check(free_valid == 1'b0, "R1 after reset free_valid", int'(free_valid), 0);

        // R2 literal, R4 unreferenced, R5 line-held, R6 uncompressed / masked
        alloc(5); alloc(300); alloc(310); alloc(311); alloc(312);
        exp_q.push_back(300); exp_q.push_back(311); exp_q.push_back(312);
        ticks(2000);
        check(exp_q.size() == 0, "R4/R6 pending frees after aging", exp_q.size(), 0);
        check(unexpected == 0, "R2/R3/R5 no stray free", unexpected, 0);

        // R7 codec marks keep an entry, then it is freed
        alloc(320);
        for (int k = 0; k < 60; k++) begin
            mark(320);
            ticks(8);
        end
        check(unexpected == 0, "R7 marked entry kept", unexpected, 0);
        exp_q.push_back(320);
        ticks(1000);
        check(exp_q.size() == 0, "R7 freed after marks stop", exp_q.size(), 0);

        // R8 busy port: no reads, no rotation
        line_port_busy = 1'b1;
        ticks(6);
        alloc(330);
        ticks(1500);
        check(line_rd_en == 1'b0, "R8 no read while busy", int'(line_rd_en), 0);
        check(unexpected == 0, "R8 flag persists while busy", unexpected, 0);
        line_port_busy = 1'b0;
        exp_q.push_back(330);
        ticks(1000);
        check(exp_q.size() == 0, "R8 freed after port frees", exp_q.size(), 0);

        // R9 continuous codec traffic stalls the purge
        alloc(340);
        @(posedge clk); #1;
        mark_valid = 1'b1; mark_code = 9'd100;
        ticks(1000);
        check(unexpected == 0 && free_valid == 1'b0, "R9 purge held", int'(free_valid), 0);
        mark_valid = 1'b0;
        exp_q.push_back(340);
        ticks(1000);
        check(exp_q.size() == 0, "R9 freed after traffic", exp_q.size(), 0);

        // R11 backpressure with more frees than FIFO depth
        free_ready = 1'b0;
        for (int c = 400; c < 406; c++) begin
            alloc(c);
            exp_q.push_back(c);
        end
        ticks(1000);
        begin
            int held;
            held = int'(free_code);
            check(free_valid == 1'b1, "R11 valid while stalled", int'(free_valid), 1);
            ticks(5);
            check(int'(free_code) == held && free_valid, "R11 code held", int'(free_code), held);
        end
        free_ready = 1'b1;
        ticks(1000);
        check(exp_q.size() == 0, "R11 no code lost", exp_q.size(), 0);

        // R10 a freed code allocated again is freed once more
        alloc(300);
        exp_q.push_back(300);
        ticks(1000);
        check(exp_q.size() == 0, "R10 reallocated code freed", exp_q.size(), 0);
        check(unexpected == 0, "R10 no double free", unexpected, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule